// File: doc/BRIEF.md
# Regulator Over-Drive Mode Controller

This block steps a core voltage regulator from its normal operating point into a boosted over-drive point and back again. Software sets two configuration bits with a single write strobe: a prepare bit and a boost bit. The prepare bit raises a preparation request to the regulator. Once the regulator acknowledges, a prepare-ready flag goes high. Only after that flag is high does the boost bit raise the actual switch request. While that switch is in flight the controller holds the system stalled. When the regulator acknowledges the switch, a boost-ready flag is raised.

A switch is started only while it is legal: the system clock must come from an oscillator rather than the PLL, and no peripheral clock may be enabled. If a peripheral clock enable turns up while a switch is in flight, a sticky violation flag is set. The mode is left either by clearing both bits in one write or by clearing the boost bit first and the prepare bit later. A stop-mode event wipes all configuration and status, so software has to start again from the beginning. The regulator's analog side is modelled inside the block by two delay-based acknowledge stubs.

Top module: `overdrive_ctl`

## Requirements
- R1: After reset, cfgPrep, cfgBoost, prepReady, boostReady, sysStall and periphViolation are all 0.
- R2: A write with wrPrep=1 sets cfgPrep. prepReady rises exactly PREP_DELAY+1 clock edges after the write edge, because status follows the regulator acknowledge by one cycle.
- R3: A boost bit written while prepReady is 0 is held pending. No stall or switch starts before prepReady is 1, and the pending switch starts by itself once it is.
- R4: sysStall is high for exactly SWITCH_DELAY+1 cycles per switch. boostReady rises in the same cycle that sysStall falls, and the two are never high together.
- R5: switchLegal is 1 exactly when clkSrcPll=0 and periphClkEn=0. A switch never starts while switchLegal is 0 and stays pending until it is 1.
- R6: periphClkEn=1 during a cycle with sysStall=1 sets periphViolation on the next edge. The flag stays set until stop or reset.
- R7: A single write that clears both bits drops prepReady and then boostReady, with no stall.
- R8: Clearing only the boost bit drops boostReady while prepReady stays 1. A later write clearing the prepare bit drops prepReady.
- R9: stopEnter=1 clears both bits, both ready flags, the stall and the violation flag on the next edge. This holds even when the switch acknowledge lands in that same cycle. Nothing becomes ready again until software writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrPrep | input | 1 | Prepare bit value written |
| wrBoost | input | 1 | Boost (switch) bit value written |
| clkSrcPll | input | 1 | 1 when the system clock comes from the PLL |
| periphClkEn | input | 1 | Any peripheral clock enable asserted |
| stopEnter | input | 1 | Stop-mode entry event |
| cfgPrep | output | 1 | Prepare bit readback |
| cfgBoost | output | 1 | Boost bit readback |
| prepReady | output | 1 | Over-drive preparation complete |
| boostReady | output | 1 | Regulator switch to over-drive complete |
| sysStall | output | 1 | System held stalled during the switch |
| switchLegal | output | 1 | Conditions allow a switch to start |
| periphViolation | output | 1 | Sticky: peripheral clock enabled during a switch |

## Verification
Two functions can land in the same cycle: a stop event and the regulator's switch acknowledge. The bench provokes this by watching for the stall to rise and then counting SWITCH_DELAY cycles. It then drives stopEnter so that it is sampled on the very edge where boostReady would otherwise rise. The event scoreboard then has to see prepReady and the stall fall while boostReady never rises, and the configuration readback must show zero. This proves that stop takes priority over the late acknowledge.

// File: rtl/overdrive_ctl_pkg.sv
package overdrive_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_PREPPED   = 2'd1,
    ST_SWITCHING = 2'd2,
    ST_BOOSTED   = 2'd3
  } odState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic boostSet;
    logic boostClr;
  } odStrobe_t;
endpackage

// File: rtl/overdrive_ack_stub.sv
// Delay-based regulator acknowledge model: ack rises DELAY edges after req
// rises, and drops on the edge after req drops.
module overdrive_ack_stub #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  localparam int CntW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CntW-1:0] LastCnt = CntW'(DELAY - 1);

  logic [CntW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !req) begin
      cnt <= '0;
      ack <= 1'b0;
    end else if (!ack) begin
      if (cnt == LastCnt) ack <= 1'b1;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/overdrive_ctl_fsm.sv
module overdrive_ctl_fsm
  import overdrive_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stopEnter,
  input  logic      prepBit,
  input  logic      boostBit,
  input  logic      prepReady,
  input  logic      boostReady,
  input  logic      boostAck,
  input  logic      clkSrcPll,
  input  logic      periphClkEn,
  output odStrobe_t strobe,
  output logic      sysStall,
  output logic      switchLegal
);
  odState_e state, nextState;

  assign switchLegal = !clkSrcPll && !periphClkEn;
  assign sysStall    = (state == ST_SWITCHING);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (prepBit && prepReady) nextState = ST_PREPPED;
      end
      ST_PREPPED: begin
        if (!prepBit || !prepReady) begin
          nextState = ST_IDLE;
        end else if (boostBit && switchLegal) begin
          strobe.boostSet = 1'b1;
          nextState       = ST_SWITCHING;
        end
      end
      ST_SWITCHING, ST_BOOSTED: begin
        if (!prepBit || !boostBit) begin
          strobe.boostClr = 1'b1;
          nextState       = prepBit ? ST_PREPPED : ST_IDLE;
        end else if (state == ST_SWITCHING && boostAck) begin
          nextState = ST_BOOSTED;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (stopEnter) begin
      strobe    = '{boostSet: 1'b0, boostClr: 1'b1};
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  // R3: the stall only happens once preparation is complete
  p_stall_after_prep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sysStall |-> prepReady);

  // R5: a switch only starts under legal conditions
  p_switch_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysStall) |-> $past(switchLegal));

  // R4: stall and boost-ready are mutually exclusive
  p_stall_excl_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sysStall |-> !boostReady);
endmodule

// File: rtl/overdrive_ctl_dp.sv
module overdrive_ctl_dp
  import overdrive_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrEn,
  input  logic      wrPrep,
  input  logic      wrBoost,
  input  logic      stopEnter,
  input  odStrobe_t strobe,
  input  logic      prepAck,
  input  logic      boostAck,
  input  logic      sysStall,
  input  logic      periphClkEn,
  output logic      prepBit,
  output logic      boostBit,
  output logic      boostReq,
  output logic      prepReady,
  output logic      boostReady,
  output logic      violation
);
  always_ff @(posedge clk) begin
    if (!rst_n || stopEnter) begin
      prepBit    <= 1'b0;
      boostBit   <= 1'b0;
      boostReq   <= 1'b0;
      prepReady  <= 1'b0;
      boostReady <= 1'b0;
      violation  <= 1'b0;
    end else begin
      if (wrEn) begin
        prepBit  <= wrPrep;
        boostBit <= wrBoost;
      end
      if (strobe.boostSet)      boostReq <= 1'b1;
      else if (strobe.boostClr) boostReq <= 1'b0;
      prepReady  <= prepAck && prepBit;
      boostReady <= boostAck && boostReq;
      if (sysStall && periphClkEn) violation <= 1'b1;
    end
  end

  // R9: stop wipes configuration and status
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stopEnter |=> (!prepBit && !boostBit && !prepReady && !boostReady && !violation));

  // R6: peripheral clock during the switch is flagged
  p_periph_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sysStall && periphClkEn && !stopEnter) |=> violation);

  // R6: flag is sticky until stop
  p_violation_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !stopEnter) |=> violation);

  // R2: ready follows the regulator acknowledge
  p_ready_follows_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prepReady) |-> $past(prepAck));
endmodule

// File: rtl/overdrive_ctl.sv
module overdrive_ctl #(
  parameter int PREP_DELAY   = 8,
  parameter int SWITCH_DELAY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrEn,
  input  logic wrPrep,
  input  logic wrBoost,
  input  logic clkSrcPll,
  input  logic periphClkEn,
  input  logic stopEnter,
  output logic cfgPrep,
  output logic cfgBoost,
  output logic prepReady,
  output logic boostReady,
  output logic sysStall,
  output logic switchLegal,
  output logic periphViolation
);
  import overdrive_ctl_pkg::*;

  odStrobe_t strobe;
  logic boostReq, prepAck, boostAck;

  overdrive_ctl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stopEnter(stopEnter),
    .prepBit(cfgPrep), .boostBit(cfgBoost),
    .prepReady(prepReady), .boostReady(boostReady), .boostAck(boostAck),
    .clkSrcPll(clkSrcPll), .periphClkEn(periphClkEn),
    .strobe(strobe), .sysStall(sysStall), .switchLegal(switchLegal)
  );

  overdrive_ctl_dp u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrPrep(wrPrep), .wrBoost(wrBoost),
    .stopEnter(stopEnter), .strobe(strobe), .prepAck(prepAck), .boostAck(boostAck),
    .sysStall(sysStall), .periphClkEn(periphClkEn),
    .prepBit(cfgPrep), .boostBit(cfgBoost), .boostReq(boostReq),
    .prepReady(prepReady), .boostReady(boostReady), .violation(periphViolation)
  );

  overdrive_ack_stub #(.DELAY(PREP_DELAY)) u_prepStub (
    .clk(clk), .rst_n(rst_n), .req(cfgPrep), .ack(prepAck)
  );

  overdrive_ack_stub #(.DELAY(SWITCH_DELAY)) u_boostStub (
    .clk(clk), .rst_n(rst_n), .req(boostReq), .ack(boostAck)
  );
endmodule

// File: tb/overdrive_ctl_test.sv
`timescale 1ns/1ps
module overdrive_ctl_test;
  localparam int N1 = 6;
  localparam int N2 = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, wrPrep = 1'b0, wrBoost = 1'b0;
  logic clkSrcPll = 1'b0, periphClkEn = 1'b0, stopEnter = 1'b0;
  logic cfgPrep, cfgBoost, prepReady, boostReady, sysStall, switchLegal, periphViolation;

  always #2.5 clk = ~clk;

  overdrive_ctl #(.PREP_DELAY(N1), .SWITCH_DELAY(N2)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrPrep(wrPrep), .wrBoost(wrBoost),
    .clkSrcPll(clkSrcPll), .periphClkEn(periphClkEn), .stopEnter(stopEnter),
    .cfgPrep(cfgPrep), .cfgBoost(cfgBoost), .prepReady(prepReady),
    .boostReady(boostReady), .sysStall(sysStall), .switchLegal(switchLegal),
    .periphViolation(periphViolation)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit monOn = 1'b0;

  // scoreboard: sig 0 = prepReady, 1 = boostReady, 2 = sysStall
  typedef struct {
    int    sig;
    bit    val;
    string req;
  } ev_t;
  ev_t expQ[$];
  logic [2:0] prevV;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectEv(int sig, bit val, string req);
    ev_t e;
    e.sig = sig; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic doWrite(bit p, bit b);
    @(negedge clk);
    wrEn = 1'b1; wrPrep = p; wrBoost = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // monitor: pops expected flag transitions in order prep, boost, stall
  always @(negedge clk) begin
    if (monOn) begin
      logic [2:0] cur;
      cur = {sysStall, boostReady, prepReady};
      for (int i = 0; i < 3; i++) begin
        if (cur[i] !== prevV[i]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R3/R4/R9 unexpected event", i * 10 + int'(cur[i]), -1);
          end else begin
            ev_t e;
            e = expQ.pop_front();
            check(e.sig == i && e.val == cur[i], e.req,
                  i * 10 + int'(cur[i]), e.sig * 10 + int'(e.val));
          end
        end
      end
      prevV = cur;
    end
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfgPrep == 0 && cfgBoost == 0, "R1 cfg bits", {cfgPrep, cfgBoost}, 0);
    check(prepReady == 0 && boostReady == 0, "R1 ready flags", {prepReady, boostReady}, 0);
    check(sysStall == 0 && periphViolation == 0, "R1 stall/violation", {sysStall, periphViolation}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfgPrep == 0 && prepReady == 0 && sysStall == 0, "R1 after release", {cfgPrep, prepReady, sysStall}, 0);
    check(switchLegal == 1, "R5 legal at idle", switchLegal, 1);
    prevV = {sysStall, boostReady, prepReady};
    monOn = 1'b1;

    // R2/R3/R4: enable and switch written together; switch held pending
    expectEv(0, 1, "R2 prep rise");
    expectEv(2, 1, "R3 stall after prep");
    expectEv(1, 1, "R4 boost ready");
    expectEv(2, 0, "R4 stall fall");
    doWrite(1, 1);
    check(cfgPrep == 1 && cfgBoost == 1, "R2 cfg readback", {cfgPrep, cfgBoost}, 3);
    n = 0;
    while (!prepReady) begin @(negedge clk); n++; end
    check(n == N1 + 1, "R2 prep latency", n, N1 + 1);
    check(sysStall == 0, "R3 no stall at prep rise", sysStall, 0);
    while (!sysStall) @(negedge clk);
    n = 0;
    while (sysStall) begin @(negedge clk); n++; end
    check(n == N2 + 1, "R4 stall length", n, N2 + 1);
    check(boostReady == 1, "R4 ready when stall falls", boostReady, 1);

    // R8: sequence two
    expectEv(1, 0, "R8 boost fall");
    doWrite(1, 0);
    repeat (4) @(negedge clk);
    check(prepReady == 1 && boostReady == 0, "R8 prep kept", {prepReady, boostReady}, 2);
    expectEv(0, 0, "R8 prep fall");
    doWrite(0, 0);
    repeat (4) @(negedge clk);
    check(prepReady == 0, "R8 prep dropped", prepReady, 0);

    // R5: switch blocked while the PLL drives the system clock
    clkSrcPll = 1'b1;
    expectEv(0, 1, "R5 prep rise");
    doWrite(1, 1);
    repeat (N1 + 3 * N2) @(negedge clk);
    check(switchLegal == 0, "R5 illegal", switchLegal, 0);
    check(sysStall == 0 && boostReady == 0, "R5 switch held", {sysStall, boostReady}, 0);
    expectEv(2, 1, "R5 stall once legal");
    expectEv(1, 1, "R4 boost ready");
    expectEv(2, 0, "R4 stall fall");
    clkSrcPll = 1'b0;
    while (!sysStall) @(negedge clk);
    // R6: peripheral clock enabled during the switch
    @(negedge clk);
    check(periphViolation == 0, "R6 clean before", periphViolation, 0);
    periphClkEn = 1'b1;
    @(negedge clk);
    periphClkEn = 1'b0;
    check(periphViolation == 1, "R6 flagged", periphViolation, 1);
    while (sysStall) @(negedge clk);
    check(boostReady == 1, "R4 ready after switch", boostReady, 1);

    // R7: sequence one
    expectEv(0, 0, "R7 prep fall");
    expectEv(1, 0, "R7 boost fall");
    doWrite(0, 0);
    repeat (4) @(negedge clk);
    check(prepReady == 0 && boostReady == 0 && sysStall == 0, "R7 all low", {prepReady, boostReady, sysStall}, 0);
    check(periphViolation == 1, "R6 sticky", periphViolation, 1);

    // R9: stop in the cycle the switch acknowledge lands
    expectEv(0, 1, "R9 prep rise");
    expectEv(2, 1, "R9 stall rise");
    doWrite(1, 1);
    while (!sysStall) @(negedge clk);
    repeat (N2) @(negedge clk);
    expectEv(0, 0, "R9 prep cleared by stop");
    expectEv(2, 0, "R9 stall cleared by stop");
    stopEnter = 1'b1;
    @(negedge clk);
    stopEnter = 1'b0;
    check(cfgPrep == 0 && cfgBoost == 0, "R9 cfg cleared", {cfgPrep, cfgBoost}, 0);
    check(boostReady == 0 && sysStall == 0, "R9 stop wins over ack", {boostReady, sysStall}, 0);
    check(periphViolation == 0, "R9 violation cleared", periphViolation, 0);
    repeat (2 * (N1 + N2)) @(negedge clk);
    check(prepReady == 0 && boostReady == 0, "R9 stays off", {prepReady, boostReady}, 0);

    // R9/R2: re-entry needs a new write
    expectEv(0, 1, "R9 prep after rewrite");
    doWrite(1, 0);
    n = 0;
    while (!prepReady) begin @(negedge clk); n++; end
    check(n == N1 + 1, "R9 re-entry latency", n, N1 + 1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3/R4 scoreboard drained", expQ.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule